// File: doc/BRIEF.md
# Serial Flag-Offset Loader

This block fills the two threshold registers that a programmable-flag FIFO compares its fill level against. One register holds the empty-side offset and the other holds the full-side offset. Each is `W` bits wide, and the flag logic reads both in parallel. Both registers share a single `2W`-bit serial chain. The chain is fed one bit per rising edge of the serial clock while the load select and the serial enable are both high. The first bit is the least significant bit of the empty offset, and the last bit is the most significant bit of the full offset.

A synchronous master reset loads a default value into both offsets. Two select inputs pick which default is used. A complete serial sequence then overwrites both offsets at once, and a single-cycle completion pulse marks the update. A partial sequence never reaches the outputs. Bits that arrive after the chain is complete are dropped until the load select is lowered, and lowering it also abandons any sequence still in progress.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `empty_ofs` and `full_ofs` load the default `2^(s+2) - 1`, where `s` is the unsigned value of `dflt_sel`. The defaults are 3, 7, 15 or 31, so `W` must be at least 5. At the same edge the bit count clears and `load_done` goes low.
- R2: A bit is taken only at a rising edge where `load_sel` and `ser_en` are both high. An edge with `ser_en` low takes no bit and does not advance the sequence, whatever `ser_din` holds.
- R3: The k-th accepted bit of a sequence, counting from k = 0, becomes bit k of the concatenation `{full_ofs, empty_ofs}`. Bits 0 to W-1 therefore fill `empty_ofs` from its LSB, and bits W to 2W-1 fill `full_ofs`, ending with its MSB.
- R4: Both outputs take their new values at the same rising edge that accepts bit 2W-1.
- R5: `load_done` is high for exactly one cycle, starting at the edge that accepts bit 2W-1.
- R6: While a sequence is partly shifted, `empty_ofs` and `full_ofs` keep their previous values.
- R7: Once a sequence is complete, further bits are ignored while `load_sel` stays high. The outputs do not change and `load_done` stays low.
- R8: An edge with `load_sel` low discards any partly shifted bits. The next accepted bit is then bit 0 of a fresh sequence.
- R9: After `load_sel` has been lowered, a new complete sequence replaces both offsets again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial shift clock, rising edge active |
| rst_n | input | 1 | Synchronous master reset, active low |
| dflt_sel | input | 2 | Picks the default offsets loaded during reset |
| load_sel | input | 1 | High to allow serial loading; low re-arms the loader |
| ser_en | input | 1 | Serial enable; a bit is taken on each edge it is high |
| ser_din | input | 1 | Serial data bit |
| empty_ofs | output | W | Empty-side offset presented to the flag logic |
| full_ofs | output | W | Full-side offset presented to the flag logic |
| load_done | output | 1 | One-cycle pulse when a full sequence has been applied |

## Verification
The hardest case to reach from the ports is a sequence that has been interrupted or overrun. In that case a wrong bit count would show up only as a mixture of old and new bits in the offsets. The stimulus therefore abandons a sequence partway by lowering the load select, then sends a fresh pattern whose value differs in every bit from the abandoned one. It also keeps clocking inverted bits into a completed chain before re-arming. Around this, every one of the 1024 possible patterns for a 5-bit configuration is shifted in, with enable gaps placed inside some sequences.

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   dflt_sel,
  input  logic         load_sel,
  input  logic         ser_en,
  input  logic         ser_din,
  output logic [W-1:0] empty_ofs,
  output logic [W-1:0] full_ofs,
  output logic         load_done
);
  localparam int TOT = 2 * W;
  localparam int CW  = $clog2(TOT + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(TOT);
  localparam logic [CW-1:0] CNT_LAST = CW'(TOT - 1);

  logic [TOT-1:0] chain;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   dflt;
  logic           rst_q;

  wire            take = load_sel & ser_en & (cnt != CNT_FULL);
  wire            last = take & (cnt == CNT_LAST);
  wire [TOT-1:0]  nxt  = {ser_din, chain[TOT-1:1]};

  assign dflt = (W'(1) << ({1'b0, dflt_sel} + 3'd2)) - W'(1);

  always_ff @(posedge clk) begin
    rst_q <= rst_n;
    if (!rst_n) begin
      chain     <= '0;
      cnt       <= '0;
      load_done <= 1'b0;
      empty_ofs <= dflt;
      full_ofs  <= dflt;
    end else begin
      load_done <= last;
      if (!load_sel) begin
        cnt <= '0;
      end else if (take) begin
        chain <= nxt;
        cnt   <= cnt + 1'b1;
      end
      if (last) begin
        empty_ofs <= nxt[W-1:0];
        full_ofs  <= nxt[TOT-1:W];
      end
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL);

  assert_stable_partial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && !load_done) |-> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);

  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (cnt == CNT_FULL && $past(cnt) == CNT_LAST));

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_sel |=> (cnt == '0));

  assert_ignore_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_q && cnt == CNT_FULL && load_sel) |=> (!load_done && cnt == CNT_FULL));
endmodule

// File: tb/flag_offset_loader_test.sv
module flag_offset_loader_test;
  localparam int W = 5;
  localparam int TOT = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] dflt_sel = 2'd0;
  logic load_sel = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
  logic [W-1:0] empty_ofs, full_ofs;
  logic load_done;
  int checks = 0, errors = 0;
  logic [W-1:0] cur_e, cur_f;

  always #10 clk = ~clk;

  flag_offset_loader #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .dflt_sel(dflt_sel), .load_sel(load_sel),
    .ser_en(ser_en), .ser_din(ser_din), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .load_done(load_done));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [TOT-1:0] v, input bit gap);
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R6 empty", int'(empty_ofs), int'(cur_e));
        chk("R6 full", int'(full_ofs), int'(cur_f));
        chk("R6 done", int'(load_done), 0);
      end
      if (gap && i == W) begin
        load_sel = 1'b1; ser_en = 1'b0; ser_din = ~v[i];
        @(negedge clk);
      end
      load_sel = 1'b1; ser_en = 1'b1; ser_din = v[i];
    end
    @(negedge clk);
    ser_en = 1'b0;
    cur_e = v[W-1:0];
    cur_f = v[TOT-1:W];
    chk("R3 R4 empty", int'(empty_ofs), int'(cur_e));
    chk("R3 R4 full", int'(full_ofs), int'(cur_f));
    chk("R5 done high", int'(load_done), 1);
    @(negedge clk);
    chk("R5 done low", int'(load_done), 0);
  endtask

  task automatic rearm();
    @(negedge clk);
    load_sel = 1'b0;
    ser_en = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      rst_n = 1'b0;
      dflt_sel = 2'(s);
      @(negedge clk);
      @(negedge clk);
      chk("R1 empty default", int'(empty_ofs), (1 << (s + 2)) - 1);
      chk("R1 full default", int'(full_ofs), (1 << (s + 2)) - 1);
      chk("R1 done low", int'(load_done), 0);
    end
    dflt_sel = 2'd1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur_e = 5'd7;
    cur_f = 5'd7;

    for (int v = 0; v < (1 << TOT); v++) begin
      send(TOT'(v), (v % 3) == 0);
      rearm();
    end

    send(10'b1010011100, 1'b0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      load_sel = 1'b1; ser_en = 1'b1; ser_din = i[0];
      if (i > 0) begin
        chk("R7 empty", int'(empty_ofs), int'(cur_e));
        chk("R7 full", int'(full_ofs), int'(cur_f));
        chk("R7 done", int'(load_done), 0);
      end
    end
    @(negedge clk);
    ser_en = 1'b0;
    chk("R7 final", int'({full_ofs, empty_ofs}), int'(10'b1010011100));
    rearm();

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      load_sel = 1'b1; ser_en = 1'b1; ser_din = 1'b1;
    end
    rearm();
    @(negedge clk);
    chk("R8 abort empty", int'(empty_ofs), int'(cur_e));
    chk("R8 abort full", int'(full_ofs), int'(cur_f));
    send(10'b0000000000, 1'b0);
    chk("R8 fresh start", int'({full_ofs, empty_ofs}), 0);
    rearm();
    send(10'b1100110101, 1'b1);
    chk("R9 reload", int'({full_ofs, empty_ofs}), int'(10'b1100110101));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule